// File: doc/BRIEF.md
# Reloadable Prescaled Watchdog Timer

This block is a watchdog timer that software cannot stop. It divides the system clock by one of two prescale ratios and uses the result to advance an up-counter. When the counter rolls over from all-ones to zero, the block emits a one-cycle reset request and sets a sticky flag. The rest of the chip can read that flag after the reset to learn that the watchdog caused it.

The timer starts from a control-register write or from a dedicated start pin. Once it runs, only the external hardware reset stops it. To refresh it, software writes an arm command and then a confirm command as the very next register write. A refresh loads a small reload value into the most significant bits of the counter, clears the remaining low bits and clears the prescaler. The reload value therefore sets the timeout in coarse steps.

There are two registers, both written through a simple write port. The configuration register holds the reload value and the prescale select. The control register takes the start, arm and confirm commands. The counter is 15 bits wide with a 7-bit reload by default. At a 6 MHz clock the timeout ranges from 512 µs (reload all ones, fast ratio) to about 1.05 s (reload zero, slow ratio).

Top module: `wdog_timer`

## Requirements
- R1: A synchronous active-high `ext_rst` stops the timer, clears the counter, the prescaler and the reload value, selects the fast ratio, and clears `wd_rst_req` and `wd_fired`.
- R2: The timer starts running at the clock edge where either a control write (`wr_sel`=1) has `wr_data[2]`=1, or `start_pin` is high.
- R3: While the timer runs, the counter advances once every prescaler period. If the counter starts at value S at an edge where the prescaler is cleared, `wd_rst_req` is high for exactly one cycle, (2^CNT_W − S)·period edges later, at the rollover to zero.
- R4: The prescale select is `wr_data[DATA_W-1]` of a configuration write (`wr_sel`=0). Value 0 gives a period of FAST_DIV clocks and value 1 gives FAST_DIV·SLOW_MULT clocks. Changing the select clears the prescaler.
- R5: A control write with `wr_data[1]`=1 (confirm) performs a refresh when the previous register write was a control write with `wr_data[0]`=1 (arm). The refresh loads the reload value (`wr_data[RLD_W-1:0]` of the last configuration write) into counter bits CNT_W−1..CNT_W−RLD_W, clears the lower bits and clears the prescaler.
- R6: A confirm with no arm on the immediately preceding write does not refresh. Any write without the arm bit in between cancels a pending arm, including a configuration write.
- R7: Once running, the timer cannot be stopped: control writes with the start bit low, and `start_pin` going low, have no effect on counting.
- R8: `wd_fired` goes high together with the first `wd_rst_req` pulse and stays high until `ext_rst`.
- R9: While the timer is stopped, the counter does not advance and `wd_rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| ext_rst | input | 1 | Synchronous active-high hardware reset |
| start_pin | input | 1 | Hardware start request, level sampled each edge |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 configuration, 1 control |
| wr_data | input | DATA_W | Write data |
| wd_rst_req | output | 1 | One-cycle reset request on counter rollover |
| wd_fired | output | 1 | Sticky flag that a watchdog rollover occurred |

## Verification
The bench is built with an 8-bit counter and a 4-bit reload. It sweeps every reload value at the fast ratio and measures the exact cycle distance from the confirm write to the request pulse. This distance tells apart an off-by-one in the prescaler, a wrong reload bit position and low bits that were not cleared. A few reload values at the slow ratio confirm the factor between the two periods. Extra sequences do the following:
- Start by the pin and by software, then try to stop the timer; the interval between two successive pulses exposes any stop path.
- Put a configuration write between arm and confirm, or confirm with no arm; the timeout then counts from the start rather than from the refresh.
- Leave the timer idle for a long time; it must stay silent.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Register select encoding on the write port
    typedef enum logic {
        SEL_CFG  = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    // Control register command bit positions
    localparam int unsigned CTRL_ARM_BIT     = 0;
    localparam int unsigned CTRL_CONFIRM_BIT = 1;
    localparam int unsigned CTRL_START_BIT   = 2;

    // Decoded control command
    typedef struct packed {
        logic start;
        logic confirm;
        logic arm;
    } ctrl_cmd_t;

    // Refresh sequencer state
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;

    // Run state
    typedef enum logic {
        RUN_OFF = 1'b0,
        RUN_ON  = 1'b1
    } run_state_e;

    // Terminal value of the prescaler for the chosen ratio
    function automatic int unsigned pre_terminal(int unsigned fast_div,
                                                 int unsigned slow_mult,
                                                 logic slow);
        return slow ? (fast_div * slow_mult - 1) : (fast_div - 1);
    endfunction

    // Width needed to hold the slow terminal value
    function automatic int unsigned pre_width(int unsigned fast_div,
                                              int unsigned slow_mult);
        int unsigned w;
        w = $clog2(fast_div * slow_mult);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned RLD_W  = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              ext_rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [RLD_W-1:0]  reload_q,
    output logic              slow_q,
    output logic              slow_chg,
    output logic              ctrl_wr,
    output logic              cfg_wr,
    output ctrl_cmd_t         cmd
);

    localparam int unsigned SLOW_BIT = DATA_W - 1;

    reg_sel_e sel;

    always_comb begin
        sel         = reg_sel_e'(wr_sel);
        ctrl_wr     = wr_en && (sel == SEL_CTRL);
        cfg_wr      = wr_en && (sel == SEL_CFG);
        cmd.arm     = wr_data[CTRL_ARM_BIT];
        cmd.confirm = wr_data[CTRL_CONFIRM_BIT];
        cmd.start   = wr_data[CTRL_START_BIT];
        slow_chg    = cfg_wr && (wr_data[SLOW_BIT] != slow_q);
    end

    always_ff @(posedge clk) begin
        if (ext_rst) begin
            reload_q <= '0;
            slow_q   <= 1'b0;
        end else if (cfg_wr) begin
            reload_q <= wr_data[RLD_W-1:0];
            slow_q   <= wr_data[SLOW_BIT];
        end
    end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      ext_rst,
    input  logic      start_pin,
    input  logic      ctrl_wr,
    input  logic      cfg_wr,
    input  ctrl_cmd_t cmd,
    output logic      run_on,
    output logic      refresh
);

    seq_state_e seq_q, seq_d;
    run_state_e run_q, run_d;

    // Arm/confirm sequencing: the confirm must be the very next write
    always_comb begin
        seq_d   = seq_q;
        refresh = 1'b0;
        if (ctrl_wr) begin
            refresh = (seq_q == SEQ_ARMED) && cmd.confirm;
            seq_d   = cmd.arm ? SEQ_ARMED : SEQ_IDLE;
        end else if (cfg_wr) begin
            seq_d = SEQ_IDLE;
        end
    end

    // Run latch: set by software or pin, cleared only by hardware reset
    always_comb begin
        run_d = run_q;
        if (start_pin || (ctrl_wr && cmd.start)) begin
            run_d = RUN_ON;
        end
    end

    always_ff @(posedge clk) begin
        if (ext_rst) begin
            seq_q <= SEQ_IDLE;
            run_q <= RUN_OFF;
        end else begin
            seq_q <= seq_d;
            run_q <= run_d;
        end
    end

    assign run_on = (run_q == RUN_ON);

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
#(
    parameter int unsigned FAST_DIV  = 12,
    parameter int unsigned SLOW_MULT = 16
) (
    input  logic                                      clk,
    input  logic                                      ext_rst,
    input  logic                                      run_on,
    input  logic                                      clear,
    input  logic                                      slow,
    output logic [pre_width(FAST_DIV, SLOW_MULT)-1:0] pre_q,
    output logic                                      tick
);

    localparam int unsigned PRE_W = pre_width(FAST_DIV, SLOW_MULT);
    localparam logic [PRE_W-1:0] TERM_FAST =
        PRE_W'(pre_terminal(FAST_DIV, SLOW_MULT, 1'b0));
    localparam logic [PRE_W-1:0] TERM_SLOW =
        PRE_W'(pre_terminal(FAST_DIV, SLOW_MULT, 1'b1));
    localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

    logic [PRE_W-1:0] term;

    generate
        if (SLOW_MULT == 1) begin : g_single_ratio
            assign term = TERM_FAST;
        end else begin : g_dual_ratio
            assign term = slow ? TERM_SLOW : TERM_FAST;
        end
    endgenerate

    assign tick = run_on && (pre_q == term);

    always_ff @(posedge clk) begin
        if (ext_rst || clear) begin
            pre_q <= '0;
        end else if (run_on) begin
            if (tick) begin
                pre_q <= '0;
            end else begin
                pre_q <= pre_q + PRE_ONE;
            end
        end
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 15,
    parameter int unsigned RLD_W = 7
) (
    input  logic             clk,
    input  logic             ext_rst,
    input  logic             tick,
    input  logic             refresh,
    input  logic [RLD_W-1:0] reload_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wd_rst_req,
    output logic             wd_fired
);

    localparam int unsigned LOW_W = CNT_W - RLD_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] load_val;
    logic             wrap;

    generate
        if (LOW_W > 0) begin : g_low_clear
            assign load_val = {reload_q, {LOW_W{1'b0}}};
        end else begin : g_full_load
            assign load_val = reload_q;
        end
    endgenerate

    // A refresh on the rollover edge wins and suppresses the request
    assign wrap = tick && (&cnt_q) && !refresh;

    always_ff @(posedge clk) begin
        if (ext_rst) begin
            cnt_q      <= '0;
            wd_rst_req <= 1'b0;
            wd_fired   <= 1'b0;
        end else begin
            if (refresh) begin
                cnt_q <= load_val;
            end else if (tick) begin
                cnt_q <= cnt_q + CNT_ONE;
            end
            wd_rst_req <= wrap;
            if (wrap) begin
                wd_fired <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W     = 15,
    parameter int unsigned RLD_W     = 7,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned FAST_DIV  = 12,
    parameter int unsigned SLOW_MULT = 16
) (
    input  logic              clk,
    input  logic              ext_rst,
    input  logic              start_pin,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wd_rst_req,
    output logic              wd_fired
);

    localparam int unsigned PRE_W = pre_width(FAST_DIV, SLOW_MULT);

    logic [RLD_W-1:0] reload_q;
    logic             slow_q;
    logic             slow_chg;
    logic             ctrl_wr;
    logic             cfg_wr;
    ctrl_cmd_t        cmd;
    logic             run_on;
    logic             refresh;
    logic [PRE_W-1:0] pre_q;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;

    wdog_regs #(
        .RLD_W (RLD_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk     (clk),
        .ext_rst (ext_rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .reload_q(reload_q),
        .slow_q  (slow_q),
        .slow_chg(slow_chg),
        .ctrl_wr (ctrl_wr),
        .cfg_wr  (cfg_wr),
        .cmd     (cmd)
    );

    wdog_ctrl u_ctrl (
        .clk      (clk),
        .ext_rst  (ext_rst),
        .start_pin(start_pin),
        .ctrl_wr  (ctrl_wr),
        .cfg_wr   (cfg_wr),
        .cmd      (cmd),
        .run_on   (run_on),
        .refresh  (refresh)
    );

    wdog_prescaler #(
        .FAST_DIV (FAST_DIV),
        .SLOW_MULT(SLOW_MULT)
    ) u_pre (
        .clk    (clk),
        .ext_rst(ext_rst),
        .run_on (run_on),
        .clear  (refresh || slow_chg),
        .slow   (slow_q),
        .pre_q  (pre_q),
        .tick   (tick)
    );

    wdog_counter #(
        .CNT_W(CNT_W),
        .RLD_W(RLD_W)
    ) u_cnt (
        .clk       (clk),
        .ext_rst   (ext_rst),
        .tick      (tick),
        .refresh   (refresh),
        .reload_q  (reload_q),
        .cnt_q     (cnt_q),
        .wd_rst_req(wd_rst_req),
        .wd_fired  (wd_fired)
    );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W     = 15,
    parameter int unsigned RLD_W     = 7,
    parameter int unsigned FAST_DIV  = 12,
    parameter int unsigned SLOW_MULT = 16
) (
    input logic                                      clk,
    input logic                                      ext_rst,
    input logic                                      run_on,
    input logic                                      refresh,
    input logic                                      slow_q,
    input logic [pre_width(FAST_DIV, SLOW_MULT)-1:0] pre_q,
    input logic [CNT_W-1:0]                          cnt_q,
    input logic [RLD_W-1:0]                          reload_q,
    input logic                                      wd_rst_req,
    input logic                                      wd_fired
);

    localparam int unsigned LOW_W = CNT_W - RLD_W;
    localparam int unsigned PRE_W = pre_width(FAST_DIV, SLOW_MULT);
    localparam logic [PRE_W-1:0] MAX_FAST =
        PRE_W'(pre_terminal(FAST_DIV, SLOW_MULT, 1'b0));
    localparam logic [PRE_W-1:0] MAX_SLOW =
        PRE_W'(pre_terminal(FAST_DIV, SLOW_MULT, 1'b1));

    // R3: request lasts one cycle
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (ext_rst)
        wd_rst_req |=> !wd_rst_req);

    // R3: request coincides with the counter having rolled to zero
    assert_req_at_wrap_R3: assert property (@(posedge clk) disable iff (ext_rst)
        wd_rst_req |-> (cnt_q == '0));

    // R4: prescaler stays inside the selected period
    assert_pre_in_range_R4: assert property (@(posedge clk) disable iff (ext_rst)
        pre_q <= (slow_q ? MAX_SLOW : MAX_FAST));

    // R5: a refresh loads the reload value on top and zeros below, prescaler cleared
    assert_refresh_load_R5: assert property (@(posedge clk) disable iff (ext_rst)
        refresh |=> ((cnt_q[LOW_W-1:0] == '0) &&
                     (cnt_q[CNT_W-1:LOW_W] == $past(reload_q)) &&
                     (pre_q == '0)));

    // R7: nothing but reset stops a running timer
    assert_cannot_stop_R7: assert property (@(posedge clk) disable iff (ext_rst)
        run_on |=> run_on);

    // R8: the flag accompanies every request and is sticky
    assert_fired_with_req_R8: assert property (@(posedge clk) disable iff (ext_rst)
        wd_rst_req |-> wd_fired);

    assert_fired_sticky_R8: assert property (@(posedge clk) disable iff (ext_rst)
        wd_fired |=> wd_fired);

    // R9: a stopped timer holds its count and never requests reset
    assert_stopped_hold_R9: assert property (@(posedge clk) disable iff (ext_rst)
        (!run_on && !refresh) |=> $stable(cnt_q));

    assert_stopped_quiet_R9: assert property (@(posedge clk) disable iff (ext_rst)
        !run_on |-> !wd_rst_req);

endmodule

bind wdog_timer wdog_timer_chk #(
    .CNT_W    (CNT_W),
    .RLD_W    (RLD_W),
    .FAST_DIV (FAST_DIV),
    .SLOW_MULT(SLOW_MULT)
) u_chk (
    .clk       (clk),
    .ext_rst   (ext_rst),
    .run_on    (run_on),
    .refresh   (refresh),
    .slow_q    (slow_q),
    .pre_q     (pre_q),
    .cnt_q     (cnt_q),
    .reload_q  (reload_q),
    .wd_rst_req(wd_rst_req),
    .wd_fired  (wd_fired)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;

    localparam int CNT_W     = 8;
    localparam int RLD_W     = 4;
    localparam int DATA_W    = 8;
    localparam int FAST_DIV  = 12;
    localparam int SLOW_MULT = 16;
    localparam int LOW_W     = CNT_W - RLD_W;
    localparam int FULL      = 1 << CNT_W;
    localparam int MAX_CYC   = 190000;

    localparam logic [7:0] C_ARM     = 8'h01;
    localparam logic [7:0] C_CONFIRM = 8'h02;
    localparam logic [7:0] C_START   = 8'h04;

    logic              clk = 1'b0;
    logic              ext_rst = 1'b1;
    logic              start_pin = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_sel = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wd_rst_req;
    logic              wd_fired;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    wdog_timer #(
        .CNT_W    (CNT_W),
        .RLD_W    (RLD_W),
        .DATA_W   (DATA_W),
        .FAST_DIV (FAST_DIV),
        .SLOW_MULT(SLOW_MULT)
    ) uut (
        .clk       (clk),
        .ext_rst   (ext_rst),
        .start_pin (start_pin),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .wd_rst_req(wd_rst_req),
        .wd_fired  (wd_fired)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog on the bench itself
    always @(negedge clk) begin
        if (!done && cyc > MAX_CYC) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected <= %0d", cyc, MAX_CYC);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        ext_rst = 1'b1;
        @(negedge clk);
        ext_rst = 1'b0;
    endtask

    // Returns the index of the edge at which the write took effect
    task automatic do_write(input logic sel, input logic [7:0] data, output int edge_idx);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
        edge_idx = cyc;
    endtask

    task automatic pin_start(output int edge_idx);
        @(negedge clk);
        start_pin = 1'b1;
        @(negedge clk);
        start_pin = 1'b0;
        edge_idx = cyc;
    endtask

    // Waits for the request; returns the edge index or -1 on timeout
    task automatic wait_req(input int limit, output int edge_idx);
        edge_idx = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (wd_rst_req) begin
                edge_idx = cyc;
                break;
            end
        end
    endtask

    function automatic logic [7:0] cfg_word(input int rld, input bit slow);
        return {slow, 3'b000, 4'(rld)};
    endfunction

    int e0, e1, ep, tmo;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        ext_rst = 1'b0;
        @(negedge clk);
        check("R1 req after reset", int'(wd_rst_req), 0);
        check("R1 fired after reset", int'(wd_fired), 0);

        // R9: stopped timer stays silent, even across a refresh
        do_write(1'b0, cfg_word(15, 1'b0), e0);
        do_write(1'b1, C_ARM, e0);
        do_write(1'b1, C_CONFIRM, e0);
        wait_req(4000, ep);
        check("R9 no request while stopped", ep, -1);
        check("R9 fired while stopped", int'(wd_fired), 0);

        // R3 R5: sweep every reload at the fast ratio
        for (int r = 0; r < (1 << RLD_W); r++) begin
            do_reset();
            do_write(1'b0, cfg_word(r, 1'b0), e0);
            do_write(1'b1, C_START, e0);
            do_write(1'b1, C_ARM, e0);
            do_write(1'b1, C_CONFIRM, e1);
            tmo = (FULL - (r << LOW_W)) * FAST_DIV;
            wait_req(tmo + 50, ep);
            check($sformatf("R5 R3 timeout fast reload %0d", r), ep - e1, tmo);
            check("R8 fired with request", int'(wd_fired), 1);
            @(negedge clk);
            check("R3 pulse width", int'(wd_rst_req), 0);
        end

        // R4: slow ratio for the two largest reloads
        for (int r = (1 << RLD_W) - 2; r < (1 << RLD_W); r++) begin
            do_reset();
            do_write(1'b0, cfg_word(r, 1'b1), e0);
            do_write(1'b1, C_START, e0);
            do_write(1'b1, C_ARM, e0);
            do_write(1'b1, C_CONFIRM, e1);
            tmo = (FULL - (r << LOW_W)) * FAST_DIV * SLOW_MULT;
            wait_req(tmo + 50, ep);
            check($sformatf("R4 timeout slow reload %0d", r), ep - e1, tmo);
        end

        // R1: reset clears reload and ratio (previous state: reload 15, slow)
        do_reset();
        do_write(1'b1, C_START, e0);
        do_write(1'b1, C_ARM, e0);
        do_write(1'b1, C_CONFIRM, e1);
        wait_req(FULL * FAST_DIV + 50, ep);
        check("R1 reload and ratio cleared", ep - e1, FULL * FAST_DIV);

        // R2 R7: pin start, then stop attempts; second pulse one full period later
        do_reset();
        pin_start(e0);
        do_write(1'b1, 8'h00, e1);
        wait_req(FULL * FAST_DIV + 50, ep);
        check("R2 pin start timeout", ep - e0, FULL * FAST_DIV);
        e1 = ep;
        wait_req(FULL * FAST_DIV + 50, ep);
        check("R7 keeps running after rollover", ep - e1, FULL * FAST_DIV);

        // R8: flag stays set through writes, cleared by reset
        do_write(1'b1, C_ARM, e0);
        do_write(1'b0, cfg_word(3, 1'b0), e0);
        repeat (40) @(negedge clk);
        check("R8 fired sticky", int'(wd_fired), 1);
        do_reset();
        check("R8 fired cleared by reset", int'(wd_fired), 0);

        // R6: configuration write between arm and confirm cancels the arm
        do_write(1'b0, cfg_word(15, 1'b0), e0);
        do_write(1'b1, C_START, e0);
        do_write(1'b1, C_ARM, e1);
        do_write(1'b0, cfg_word(15, 1'b0), e1);
        do_write(1'b1, C_CONFIRM, e1);
        wait_req(FULL * FAST_DIV + 50, ep);
        check("R6 intervening write cancels arm", ep - e0, FULL * FAST_DIV);

        // R6: confirm without arm is ignored
        do_reset();
        do_write(1'b0, cfg_word(15, 1'b0), e0);
        do_write(1'b1, C_START, e0);
        do_write(1'b1, C_CONFIRM, e1);
        wait_req(FULL * FAST_DIV + 50, ep);
        check("R6 confirm without arm", ep - e0, FULL * FAST_DIV);

        // R2: software start with stop attempt via start bit low (R7)
        do_reset();
        do_write(1'b1, C_START, e0);
        do_write(1'b1, 8'h00, e1);
        wait_req(FULL * FAST_DIV + 50, ep);
        check("R2 R7 software start not stoppable", ep - e0, FULL * FAST_DIV);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule